// File: doc/BRIEF.md
# Clock Ratio Fanout Divider

This block takes a fast source clock, nominally four times a reference rate, and produces three classes of clock from it. A full-rate output follows the source. A half-rate output is divided by two. A bank of six outputs runs at either a quarter or a half of the source, and the choice can be changed at run time. A feedback output always runs at the quarter (base) rate, so an outside loop divider that watches it keeps a fixed ratio.

One two-bit counter chain produces every divided output. A select picks the clock that drives this chain. It is either the normal source or a separate test clock, and the test clock lets the counter and the output fan-out be exercised without the oscillator. A bypass select sends an external clock, undivided, to every output and freezes the counter. An active-low enable puts the full-rate, half-rate and bank outputs into high impedance. An asynchronous active-low reset clears the counter. The reset is released in step with the active clock through a two-stage synchronizer.

Top module: `clk_ratio_fanout`

## Requirements
- R1: While `rst_n_i` is low, and for the first two active rising edges after it goes high, the counter stays at zero: `mid_o`, `fbk_o` and every `bank_o` bit are 0 and `fast_o` follows the active clock. The registered ratio select resets to 1 (quarter rate).
- R2: With `oe_n_i` high and `ext_sel_i` low, `fast_o` equals the active clock.
- R3: `mid_o` toggles on every counted rising edge of the active clock and goes high on the first counted edge.
- R4: When the registered ratio select is 1, each bank bit equals the quarter-rate signal. That signal goes high on the second counted edge and toggles every second edge, in phase with `fbk_o`. When the registered select is 0, each bank bit equals `mid_o`.
- R5: `ratio_sel_i` is sampled into the registered select only on the rising edge where the count wraps from 3 to 0. A change at any other point has no effect on the bank until that edge.
- R6: All six `bank_o` bits carry the same value in every cycle.
- R7: `fbk_o` runs at the quarter rate whatever the ratio select is, and `oe_n_i` does not put it into high impedance.
- R8: With `skew_sel_i` high, the counter chain and `fast_o` run from `tst_clk_i` in place of `src_clk_i`. The division rules of R3 to R5 still apply. The select is changed only while reset is held.
- R9: With `oe_n_i` low, `fast_o`, `mid_o` and all bank bits are high impedance whatever the other selects are. The counter keeps running.
- R10: With `ext_sel_i` high, `fast_o`, `mid_o`, every bank bit and `fbk_o` all equal `ext_clk_i`. The counter holds its value and starts counting again from that value when the select returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Fast source clock (4x reference) |
| tst_clk_i | input | 1 | Test clock that replaces the source when selected |
| ext_clk_i | input | 1 | External clock sent straight to the outputs in bypass |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| skew_sel_i | input | 1 | 1: counter chain clocked from tst_clk_i |
| ext_sel_i | input | 1 | 1: all outputs carry ext_clk_i, counter holds |
| ratio_sel_i | input | 1 | 1: bank at quarter rate, 0: bank at half rate |
| oe_n_i | input | 1 | Active-low output enable |
| fast_o | output | 1 | Full-rate clock |
| mid_o | output | 1 | Half-rate clock |
| bank_o | output | 6 | Six phase-aligned bank clocks |
| fbk_o | output | 1 | Quarter-rate feedback clock |

## Verification
Two events can land on the same rising edge: the counter wrapping from 3 to 0 and a new ratio select being loaded. The bench causes this by changing the ratio pin in the half cycle just before the wrap edge. It also changes the pin in the middle of a count period, where the change must wait up to three more edges. A scoreboard model predicts the bank value at every edge from the wrap rule alone. It checks that the bank keeps its old ratio until the wrap, switches exactly on that edge, and never shows a pulse shorter than one source period. A hold in bypass that starts part way through a count is judged by whether the count continues without a gap once bypass is released.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  // divider chain: bit 0 is half rate, top bit is quarter rate
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_WRAP = '1;
  localparam logic RATIO_RST = 1'b1;

  typedef enum logic {
    SRC_DIV = 1'b0,
    SRC_EXT = 1'b1
  } out_src_e;
endpackage

// File: rtl/clkfan_rst_sync.sv
module clkfan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/clkfan_divider.sv
module clkfan_divider
  import clkfan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             ratio_i,
  output logic [CNT_W-1:0] cnt,
  output logic             ratio_q,
  output logic             half_clk,
  output logic             quarter_clk,
  output logic             bank_clk
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rq_q, rq_d;
  logic             cnt_en;

  assign cnt_en = ~hold;

  always_comb begin
    cnt_d = cnt_q;
    rq_d  = rq_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
      // new ratio only at the wrap edge, where both phases fall together
      if (cnt_q == CNT_WRAP) rq_d = ratio_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rq_q  <= RATIO_RST;
    end else begin
      cnt_q <= cnt_d;
      rq_q  <= rq_d;
    end
  end

  assign cnt         = cnt_q;
  assign ratio_q     = rq_q;
  assign half_clk    = cnt_q[0];
  assign quarter_clk = cnt_q[CNT_W-1];
  assign bank_clk    = rq_q ? cnt_q[CNT_W-1] : cnt_q[0];
endmodule

// File: rtl/clkfan_outmux.sv
module clkfan_outmux
  import clkfan_pkg::*;
#(
  parameter int BANK_W = 6
) (
  input  logic              fast_src,
  input  logic              half_src,
  input  logic              bank_src,
  input  logic              fbk_src,
  input  logic              ext_clk,
  input  logic              ext_sel,
  input  logic              oe_n,
  output logic              fast_o,
  output logic              mid_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              fbk_o
);
  out_src_e src;
  logic     fast_m, half_m, bank_m;

  assign src    = ext_sel ? SRC_EXT : SRC_DIV;
  assign fast_m = (src == SRC_EXT) ? ext_clk : fast_src;
  assign half_m = (src == SRC_EXT) ? ext_clk : half_src;
  assign bank_m = (src == SRC_EXT) ? ext_clk : bank_src;

  assign fast_o = oe_n ? fast_m : 1'bz;
  assign mid_o  = oe_n ? half_m : 1'bz;
  assign fbk_o  = (src == SRC_EXT) ? ext_clk : fbk_src;

  // one driver per bank pin, all from the same divided source
  for (genvar b = 0; b < BANK_W; b++) begin : g_bank
    assign bank_o[b] = oe_n ? bank_m : 1'bz;
  end
endmodule

// File: rtl/clk_ratio_fanout.sv
module clk_ratio_fanout
  import clkfan_pkg::*;
#(
  parameter int BANK_W    = 6,
  parameter int SYNC_STGS = 2
) (
  input  logic              src_clk_i,
  input  logic              tst_clk_i,
  input  logic              ext_clk_i,
  input  logic              rst_n_i,
  input  logic              skew_sel_i,
  input  logic              ext_sel_i,
  input  logic              ratio_sel_i,
  input  logic              oe_n_i,
  output logic              fast_o,
  output logic              mid_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              fbk_o
);
  logic             div_clk;
  logic             rst_sn;
  logic [CNT_W-1:0] cnt;
  logic             ratio_q;
  logic             half_clk, quarter_clk, bank_clk;

  // active clock for the chain: source or test clock
  assign div_clk = skew_sel_i ? tst_clk_i : src_clk_i;

  clkfan_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk    (div_clk),
    .rst_n  (rst_n_i),
    .rst_sn (rst_sn)
  );

  clkfan_divider u_div (
    .clk         (div_clk),
    .rst_n       (rst_sn),
    .hold        (ext_sel_i),
    .ratio_i     (ratio_sel_i),
    .cnt         (cnt),
    .ratio_q     (ratio_q),
    .half_clk    (half_clk),
    .quarter_clk (quarter_clk),
    .bank_clk    (bank_clk)
  );

  clkfan_outmux #(.BANK_W(BANK_W)) u_mux (
    .fast_src (div_clk),
    .half_src (half_clk),
    .bank_src (bank_clk),
    .fbk_src  (quarter_clk),
    .ext_clk  (ext_clk_i),
    .ext_sel  (ext_sel_i),
    .oe_n     (oe_n_i),
    .fast_o   (fast_o),
    .mid_o    (mid_o),
    .bank_o   (bank_o),
    .fbk_o    (fbk_o)
  );
endmodule

// File: rtl/clk_ratio_fanout_chk.sv
module clk_ratio_fanout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_sel,
  input logic [1:0] cnt,
  input logic       ratio_q,
  input logic       half_clk
);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel |=> (cnt == 2'($past(cnt) + 2'd1)));

  // R10
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |=> $stable(cnt));

  // R5
  ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> ($past(cnt) == 2'd3));

  // R3
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel |=> (half_clk != $past(half_clk)));
endmodule

bind clk_ratio_fanout clk_ratio_fanout_chk chk_i (
  .clk      (div_clk),
  .rst_n    (rst_sn),
  .ext_sel  (ext_sel_i),
  .cnt      (cnt),
  .ratio_q  (ratio_q),
  .half_clk (half_clk)
);

// File: tb/clk_ratio_fanout_tb_top.sv
module clk_ratio_fanout_tb_top;
  logic src_clk = 1'b0, tst_clk = 1'b0, ext_clk = 1'b0;
  logic rst_n, skew_sel, ext_sel, ratio_sel, oe_n;
  wire  fast, mid, fbk;
  wire  [5:0] bank;

  always #4  src_clk = ~src_clk;   // 125 MHz
  always #10 tst_clk = ~tst_clk;

  clk_ratio_fanout dut_i (
    .src_clk_i(src_clk), .tst_clk_i(tst_clk), .ext_clk_i(ext_clk),
    .rst_n_i(rst_n), .skew_sel_i(skew_sel), .ext_sel_i(ext_sel),
    .ratio_sel_i(ratio_sel), .oe_n_i(oe_n),
    .fast_o(fast), .mid_o(mid), .bank_o(bank), .fbk_o(fbk));

  typedef struct {
    logic       fast;
    logic       mid;
    logic [5:0] bank;
    logic       fbk;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  // reference model state
  logic [1:0] mc;
  logic       mrq, mrst;
  int         sync_left;

  task automatic model_edge();
    if (mrst) return;
    if (sync_left > 0) begin sync_left--; return; end
    if (ext_sel) return;
    if (mc == 2'd3) mrq = ratio_sel;
    mc = mc + 2'd1;
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    logic b;
    b      = mrq ? mc[1] : mc[0];
    e.fast = ext_sel ? ext_clk : 1'b1;
    e.mid  = ext_sel ? ext_clk : mc[0];
    e.bank = {6{ext_sel ? ext_clk : b}};
    e.fbk  = ext_sel ? ext_clk : mc[1];
    if (!oe_n) begin
      e.fast = 1'bz; e.mid = 1'bz; e.bank = 6'bzzzzzz;
    end
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (skew_sel) @(posedge tst_clk); else @(posedge src_clk);
      model_edge();
      push_exp(tag);
      #2 -> mon_ev;
      if (skew_sel) @(negedge tst_clk); else @(negedge src_clk);
    end
  endtask

  task automatic do_reset(input logic skew);
    rst_n = 1'b0; mrst = 1'b1; mc = 2'd0; mrq = 1'b1; sync_left = 2;
    #3 skew_sel = skew;
    step(3, "R1");
    rst_n = 1'b1; mrst = 1'b0;
  endtask

  // monitor: pop and compare
  always @(mon_ev) begin
    exp_t e;
    if (exp_q.size() == 0) begin
      n_fail++; $display("FAIL %s: no expected item queued", "R1");
    end else begin
      e = exp_q.pop_front();
      n_chk++;
      if (fast !== e.fast) begin n_fail++;
        $display("FAIL %s fast: got %b exp %b", e.tag, fast, e.fast); end
      if (mid !== e.mid) begin n_fail++;
        $display("FAIL %s mid: got %b exp %b", e.tag, mid, e.mid); end
      if (bank !== e.bank) begin n_fail++;
        $display("FAIL %s/R6 bank: got %b exp %b", e.tag, bank, e.bank); end
      if (fbk !== e.fbk) begin n_fail++;
        $display("FAIL %s/R7 fbk: got %b exp %b", e.tag, fbk, e.fbk); end
    end
  end

  initial begin
    rst_n = 1'b0; skew_sel = 1'b0; ext_sel = 1'b0; ratio_sel = 1'b1; oe_n = 1'b1;
    mc = 2'd0; mrq = 1'b1; mrst = 1'b1; sync_left = 2;
    @(negedge src_clk);
    // R1: reset state, then two sync edges
    do_reset(1'b0);
    #1;
    if (fast !== 1'b0) begin n_fail++;
      $display("FAIL R1 fast low phase: got %b exp 0", fast); end
    n_chk++;
    // R2 R3 R4 R6 R7: quarter-rate bank
    step(12, "R4");
    // R5: change mid-period (count 1), must wait for wrap
    while (mc != 2'd1) step(1, "R5");
    ratio_sel = 1'b0;
    step(12, "R5");
    // R5: change in the half cycle before the wrap edge
    while (mc != 2'd3) step(1, "R5");
    ratio_sel = 1'b1;
    step(8, "R5");
    // R9: outputs high impedance, counter runs (fbk checks it)
    oe_n = 1'b0;
    step(6, "R9");
    oe_n = 1'b1;
    step(3, "R9");
    // R10: bypass starting mid-count
    while (mc != 2'd2) step(1, "R10");
    ext_sel = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ext_clk = i[0];
      step(1, "R10");
    end
    ext_sel = 1'b0; ext_clk = 1'b0;
    step(6, "R10");
    // R8: test clock drives the chain, both ratios
    do_reset(1'b1);
    step(10, "R8");
    while (mc != 2'd1) step(1, "R8");
    ratio_sel = 1'b0;
    step(10, "R8");
    #20;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule